// File: doc/BRIEF.md
# Bank Role Controller for Single-Cycle Context Switching

This controller governs a small set of cache banks that serve one memory pipeline of a processor. At any moment at most one bank is attached to the execution pipeline (the active bank), at most one is attached to a copy engine that moves its contents between the bank and the level-2 cache (the swapping bank), and all others sit idle. The controller keeps, for every bank, the process ID it holds and a lifecycle state: EMPTY, LOADING, READY, ACTIVE, UNLOADING or DIRTY. A context switch to a process whose bank is already READY is a pure reassignment of roles and takes effect at the next clock edge. Loading of the next process and write-back of the previous one run in the background while the active process executes.

Two request streams enter the block. The switch stream names the process that should run next. The preload stream names a process to bring in ahead of time. Both streams use valid/ready. A transfer happens on a rising edge where both valid and ready are high. The requester holds the PID stable while valid is high and ready is low. For the switch stream, ready depends only on whether a READY or ACTIVE bank holds the requested PID. While a switch request waits, the block raises `stall` and loads the missing process itself. The copy engine is driven by a start/done handshake and is given one job at a time. Every bank that is neither active nor swapping is flagged for reduced clock and voltage.

Top module: `cbk_switch_ctrl`

## Requirements
- R1: After reset, no bank is active, no copy job is in flight, `swap_valid` and `stall` are low, `dma_start` is low, and every `lowpower` bit is high.
- R2: While both `active_valid` and `swap_valid` are high, `active_bank` differs from `swap_bank`.
- R3: When a switch request names a PID held by a READY bank, `sw_ready` is high in that same cycle, and `active_bank` shows that bank from the next edge onward. No stall cycle occurs.
- R4: When a switch request names a PID that no bank holds, `stall` stays high. The PID is loaded into the lowest-indexed EMPTY bank, and the switch then completes into that bank.
- R5: A switch request naming the PID of the active bank is accepted at once. It changes no role and starts no copy job.
- R6: At a switch, the bank that was active becomes DIRTY. Unload jobs (`dma_dir` = 0) for dirty banks are issued before any load job, lowest bank index first.
- R7: `dma_start` is a one-cycle pulse. It comes with `dma_bank`, `dma_dir` (1 = load from L2 into the bank, 0 = unload to L2) and `dma_pid`. No further pulse occurs until `dma_done` has been seen for the job in flight.
- R8: A preload of a non-resident PID is accepted only when the copy engine is idle, no bank is DIRTY, an EMPTY bank exists and no switch miss is waiting. It loads into the lowest-indexed EMPTY bank.
- R9: A preload naming a PID that is already LOADING, READY or ACTIVE is accepted at once and starts no copy job.
- R10: `lowpower[i]` is high exactly when bank i is neither the active bank nor the swapping bank.
- R11: `swap_valid` is high while a copy job is in flight, and `swap_bank` equals the `dma_bank` of that job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_valid | input | 1 | Switch request present |
| sw_ready | output | 1 | Switch request can complete this cycle |
| sw_pid | input | PID_W | Process to run next |
| pre_valid | input | 1 | Preload request present |
| pre_ready | output | 1 | Preload request accepted this cycle |
| pre_pid | input | PID_W | Process to bring in early |
| stall | output | 1 | Switch request is waiting for a load |
| active_valid | output | 1 | A bank is attached to the execution pipeline |
| active_bank | output | IDX_W | Index of the active bank |
| swap_valid | output | 1 | A bank is attached to the copy engine |
| swap_bank | output | IDX_W | Index of the swapping bank |
| lowpower | output | NUM_BANKS | Per-bank reduced clock/voltage flag |
| dma_start | output | 1 | One-cycle pulse that launches a copy job |
| dma_bank | output | IDX_W | Bank of the current copy job |
| dma_dir | output | 1 | 1 = load into bank, 0 = unload to L2 |
| dma_pid | output | PID_W | Process ID of the current copy job |
| dma_done | input | 1 | Copy engine finished the current job |

## Verification
The switch path is driven with three kinds of request. A hit on a READY bank must complete with zero stall cycles. A miss must stall, trigger a load and then complete. A request for the PID that is already running must leave every role in place. Requests are issued both after the copy engine has gone quiet and back-to-back while unloads are still in flight. The second case separates strict unload-before-load ordering and lowest-index draining from any looser scheduling. Preloads are issued both right after a switch and for PIDs that are already resident. A continuous monitor compares the active and swapping indices and the power flags on every cycle.

// File: rtl/cbk_pkg.sv
`timescale 1ns/1ps
package cbk_pkg;
  typedef enum logic [2:0] {
    BK_EMPTY, BK_LOADING, BK_READY, BK_ACTIVE, BK_UNLOADING, BK_DIRTY
  } bk_state_e;

  localparam logic DIR_UNLOAD = 1'b0;
  localparam logic DIR_LOAD   = 1'b1;
endpackage

// File: rtl/cbk_slot.sv
`timescale 1ns/1ps
module cbk_slot
  import cbk_pkg::*;
#(
  parameter int PID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_active,
  input  logic             set_dirty,
  input  logic             go_load,
  input  logic             go_unload,
  input  logic             job_done,
  input  logic [PID_W-1:0] load_pid,
  output bk_state_e        state,
  output logic [PID_W-1:0] pid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= BK_EMPTY;
      pid   <= '0;
    end else if (go_load) begin
      state <= BK_LOADING;
      pid   <= load_pid;
    end else if (go_unload) begin
      state <= BK_UNLOADING;
    end else if (job_done) begin
      state <= (state == BK_LOADING) ? BK_READY : BK_EMPTY;
    end else if (set_active) begin
      state <= BK_ACTIVE;
    end else if (set_dirty) begin
      state <= BK_DIRTY;
    end
  end

  // R8: a load only ever targets a free bank
  p_load_into_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    go_load |-> state == BK_EMPTY);
  // R6: an unload only ever targets a bank left behind by a switch
  p_unload_dirty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    go_unload |-> state == BK_DIRTY);
  // R3: only a loaded bank can be made active
  p_activate_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_active |-> state == BK_READY);
endmodule

// File: rtl/cbk_dma_sched.sv
`timescale 1ns/1ps
module cbk_dma_sched
  import cbk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int PID_W     = 8,
  parameter int IDX_W     = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_BANKS-1:0]       dirty_v,
  input  logic [NUM_BANKS-1:0]       empty_v,
  input  logic                       want_load,
  input  logic [PID_W-1:0]           load_pid,
  input  logic [NUM_BANKS*PID_W-1:0] pid_flat,
  input  logic                       dma_done,
  output logic                       busy,
  output logic                       dma_start,
  output logic [IDX_W-1:0]           dma_bank,
  output logic                       dma_dir,
  output logic [PID_W-1:0]           dma_pid,
  output logic [NUM_BANKS-1:0]       go_unload_v,
  output logic [NUM_BANKS-1:0]       go_load_v,
  output logic [NUM_BANKS-1:0]       done_v,
  output logic                       load_go
);
  logic [IDX_W-1:0] dirty_idx, empty_idx;
  logic             unload_go;

  always_comb begin
    dirty_idx = '0;
    empty_idx = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (dirty_v[i]) dirty_idx = IDX_W'(i);
      if (empty_v[i]) empty_idx = IDX_W'(i);
    end
  end

  assign unload_go   = !busy && (|dirty_v);
  assign load_go     = !busy && !(|dirty_v) && (|empty_v) && want_load;
  assign go_unload_v = unload_go ? (NUM_BANKS'(1) << dirty_idx) : '0;
  assign go_load_v   = load_go ? (NUM_BANKS'(1) << empty_idx) : '0;
  assign done_v      = (busy && dma_done) ? (NUM_BANKS'(1) << dma_bank) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      dma_start <= 1'b0;
      dma_bank  <= '0;
      dma_dir   <= DIR_UNLOAD;
      dma_pid   <= '0;
    end else begin
      dma_start <= unload_go || load_go;
      if (unload_go) begin
        busy     <= 1'b1;
        dma_bank <= dirty_idx;
        dma_dir  <= DIR_UNLOAD;
        dma_pid  <= pid_flat[dirty_idx*PID_W +: PID_W];
      end else if (load_go) begin
        busy     <= 1'b1;
        dma_bank <= empty_idx;
        dma_dir  <= DIR_LOAD;
        dma_pid  <= load_pid;
      end else if (busy && dma_done) begin
        busy <= 1'b0;
      end
    end
  end

  // R7: start is a single-cycle pulse
  p_start_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |=> !dma_start);
  // R7: a job in flight keeps its bank until done arrives
  p_job_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !dma_done |=> busy && !dma_start && $stable(dma_bank));
  // R6: no load job is launched while a dirty bank was waiting
  p_unload_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start && dma_dir == DIR_LOAD |-> $past(dirty_v) == '0);
endmodule

// File: rtl/cbk_switch_ctrl.sv
`timescale 1ns/1ps
module cbk_switch_ctrl
  import cbk_pkg::*;
#(
  parameter  int NUM_BANKS = 4,
  parameter  int PID_W     = 8,
  localparam int IDX_W     = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sw_valid,
  output logic                 sw_ready,
  input  logic [PID_W-1:0]     sw_pid,
  input  logic                 pre_valid,
  output logic                 pre_ready,
  input  logic [PID_W-1:0]     pre_pid,
  output logic                 stall,
  output logic                 active_valid,
  output logic [IDX_W-1:0]     active_bank,
  output logic                 swap_valid,
  output logic [IDX_W-1:0]     swap_bank,
  output logic [NUM_BANKS-1:0] lowpower,
  output logic                 dma_start,
  output logic [IDX_W-1:0]     dma_bank,
  output logic                 dma_dir,
  output logic [PID_W-1:0]     dma_pid,
  input  logic                 dma_done
);
  bk_state_e                  st    [NUM_BANKS];
  logic [PID_W-1:0]           pid_q [NUM_BANKS];
  logic [NUM_BANKS*PID_W-1:0] pid_flat;
  logic [NUM_BANKS-1:0] sw_hit_v, sw_res_v, pre_res_v, dirty_v, empty_v;
  logic [NUM_BANKS-1:0] set_act_v, set_dirty_v, go_load_v, go_unload_v, done_v;
  logic [IDX_W-1:0]     hit_idx;
  logic                 sw_fire, sw_miss, want_load, load_go, busy;
  logic [PID_W-1:0]     load_pid;
  logic                 act_valid_q;
  logic [IDX_W-1:0]     act_idx_q;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic live;
    assign live         = (st[g] == BK_READY) || (st[g] == BK_ACTIVE);
    assign sw_hit_v[g]  = live && (pid_q[g] == sw_pid);
    assign sw_res_v[g]  = (live || st[g] == BK_LOADING) && (pid_q[g] == sw_pid);
    assign pre_res_v[g] = (live || st[g] == BK_LOADING) && (pid_q[g] == pre_pid);
    assign dirty_v[g]   = (st[g] == BK_DIRTY);
    assign empty_v[g]   = (st[g] == BK_EMPTY);
    assign pid_flat[g*PID_W +: PID_W] = pid_q[g];
    assign set_act_v[g] = sw_fire && (hit_idx == IDX_W'(g)) && (st[g] != BK_ACTIVE);
    assign set_dirty_v[g] = sw_fire && act_valid_q && (act_idx_q == IDX_W'(g))
                            && (hit_idx != IDX_W'(g));
    assign lowpower[g]  = !(act_valid_q && act_idx_q == IDX_W'(g))
                          && !(busy && dma_bank == IDX_W'(g));

    cbk_slot #(.PID_W(PID_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_active(set_act_v[g]),
      .set_dirty (set_dirty_v[g]),
      .go_load   (go_load_v[g]),
      .go_unload (go_unload_v[g]),
      .job_done  (done_v[g]),
      .load_pid  (load_pid),
      .state     (st[g]),
      .pid       (pid_q[g])
    );
  end

  always_comb begin
    hit_idx = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--)
      if (sw_hit_v[i]) hit_idx = IDX_W'(i);
  end

  assign sw_ready  = |sw_hit_v;
  assign sw_fire   = sw_valid && sw_ready;
  assign stall     = sw_valid && !sw_ready;
  assign sw_miss   = sw_valid && !(|sw_res_v);
  assign want_load = sw_miss || (pre_valid && !(|pre_res_v));
  assign load_pid  = sw_miss ? sw_pid : pre_pid;
  assign pre_ready = (|pre_res_v) || (load_go && !sw_miss);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_valid_q <= 1'b0;
      act_idx_q   <= '0;
    end else if (sw_fire) begin
      act_valid_q <= 1'b1;
      act_idx_q   <= hit_idx;
    end
  end

  cbk_dma_sched #(.NUM_BANKS(NUM_BANKS), .PID_W(PID_W), .IDX_W(IDX_W)) u_sched (
    .clk        (clk),
    .rst_n      (rst_n),
    .dirty_v    (dirty_v),
    .empty_v    (empty_v),
    .want_load  (want_load),
    .load_pid   (load_pid),
    .pid_flat   (pid_flat),
    .dma_done   (dma_done),
    .busy       (busy),
    .dma_start  (dma_start),
    .dma_bank   (dma_bank),
    .dma_dir    (dma_dir),
    .dma_pid    (dma_pid),
    .go_unload_v(go_unload_v),
    .go_load_v  (go_load_v),
    .done_v     (done_v),
    .load_go    (load_go)
  );

  assign active_valid = act_valid_q;
  assign active_bank  = act_idx_q;
  assign swap_valid   = busy;
  assign swap_bank    = dma_bank;

  // R2: execution pipeline and copy engine never share a bank
  p_roles_apart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid_q && busy |-> act_idx_q != dma_bank);
  // R3: an accepted switch lands in the matching bank on the next edge
  p_switch_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sw_fire |=> act_valid_q && act_idx_q == $past(hit_idx));
  // R4: a stalled request leaves the active role untouched
  p_stall_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(act_idx_q) && $stable(act_valid_q));
endmodule

// File: tb/cbk_switch_ctrl_bench.sv
`timescale 1ns/1ps
module cbk_switch_ctrl_bench;
  localparam int NB = 4;
  localparam int PW = 8;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sw_valid = 1'b0, pre_valid = 1'b0, dma_done = 1'b0;
  logic [PW-1:0] sw_pid = '0, pre_pid = '0;
  logic          sw_ready, pre_ready, stall, active_valid, swap_valid;
  logic          dma_start, dma_dir;
  logic [IW-1:0] active_bank, swap_bank, dma_bank;
  logic [NB-1:0] lowpower;
  logic [PW-1:0] dma_pid;

  always #4 clk = ~clk;

  cbk_switch_ctrl #(.NUM_BANKS(NB), .PID_W(PW)) u_cbk_switch_ctrl (
    .clk(clk), .rst_n(rst_n),
    .sw_valid(sw_valid), .sw_ready(sw_ready), .sw_pid(sw_pid),
    .pre_valid(pre_valid), .pre_ready(pre_ready), .pre_pid(pre_pid),
    .stall(stall), .active_valid(active_valid), .active_bank(active_bank),
    .swap_valid(swap_valid), .swap_bank(swap_bank), .lowpower(lowpower),
    .dma_start(dma_start), .dma_bank(dma_bank), .dma_dir(dma_dir),
    .dma_pid(dma_pid), .dma_done(dma_done)
  );

  int n_tests = 0, n_fail = 0, n_viol = 0, n_jobs = 0;
  logic [2:0] job_log [64];

  // {op(0=switch,1=preload), pid, expected bank, expected hit}
  localparam logic [11:0] VEC [12] = '{
    {1'b0, 8'h10, 2'd0, 1'b0}, {1'b1, 8'h11, 2'd0, 1'b0},
    {1'b0, 8'h11, 2'd1, 1'b1}, {1'b1, 8'h12, 2'd0, 1'b0},
    {1'b0, 8'h12, 2'd0, 1'b1}, {1'b0, 8'h13, 2'd1, 1'b0},
    {1'b1, 8'h14, 2'd0, 1'b0}, {1'b1, 8'h15, 2'd0, 1'b0},
    {1'b1, 8'h16, 2'd0, 1'b0}, {1'b0, 8'h16, 2'd3, 1'b1},
    {1'b0, 8'h15, 2'd2, 1'b1}, {1'b0, 8'h14, 2'd0, 1'b1}
  };
  // {dir, bank}: dir 1 = load, 0 = unload
  localparam logic [2:0] JOBS [13] = '{
    3'b100, 3'b101, 3'b000, 3'b100, 3'b001, 3'b101, 3'b000,
    3'b100, 3'b110, 3'b111, 3'b001, 3'b010, 3'b011
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_switch(input logic [PW-1:0] pid, input int exp_bank, input logic exp_hit);
    int stalls = 0;
    int guard = 0;
    @(negedge clk);
    sw_valid = 1'b1;
    sw_pid   = pid;
    #1;
    while (!sw_ready && guard < 300) begin
      if (stall) stalls++;
      @(negedge clk);
      #1;
      guard++;
    end
    @(negedge clk);
    sw_valid = 1'b0;
    #1;
    chk(active_valid && active_bank == IW'(exp_bank), exp_hit ? "R3 bank" : "R4 bank",
        int'(active_bank), exp_bank);
    if (exp_hit) chk(stalls == 0, "R3 no stall", stalls, 0);
    else         chk(stalls > 0, "R4 stall seen", stalls, 1);
  endtask

  task automatic do_preload(input logic [PW-1:0] pid);
    int guard = 0;
    @(negedge clk);
    pre_valid = 1'b1;
    pre_pid   = pid;
    #1;
    while (!pre_ready && guard < 300) begin
      @(negedge clk);
      #1;
      guard++;
    end
    @(negedge clk);
    pre_valid = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  // copy-engine model: done arrives six cycles after the start pulse
  initial begin
    forever begin
      @(negedge clk);
      if (dma_start) begin
        if (n_jobs < 64) job_log[n_jobs] = {dma_dir, dma_bank};
        n_jobs++;
        if (!swap_valid || swap_bank != dma_bank) n_viol++;  // R11
        repeat (6) @(negedge clk);
        dma_done = 1'b1;
        @(negedge clk);
        dma_done = 1'b0;
      end
    end
  end

  // R2 / R10 monitor
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        if (active_valid && swap_valid && active_bank == swap_bank) n_viol++;
        for (int i = 0; i < NB; i++) begin
          if (lowpower[i] != !((active_valid && active_bank == IW'(i)) ||
                               (swap_valid && swap_bank == IW'(i)))) n_viol++;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int jobs_before;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(!active_valid, "R1 active", int'(active_valid), 0);
    chk(!swap_valid && !dma_start, "R1 dma idle", int'(swap_valid), 0);
    chk(lowpower == '1, "R1 lowpower", int'(lowpower), 15);
    chk(!stall, "R1 stall", int'(stall), 0);

    for (int v = 0; v < 12; v++) begin
      if (VEC[v][11]) do_preload(VEC[v][10:3]);
      else            do_switch(VEC[v][10:3], int'(VEC[v][2:1]), VEC[v][0]);
    end

    repeat (60) @(negedge clk);
    #1;
    chk(n_jobs == 13, "R6 job count", n_jobs, 13);
    for (int j = 0; j < 13; j++)
      chk(job_log[j] == JOBS[j], "R6 job order", int'(job_log[j]), int'(JOBS[j]));
    chk(!swap_valid, "R11 idle", int'(swap_valid), 0);
    chk(lowpower == 4'b1110, "R10 lowpower idle", int'(lowpower), 14);

    // R5: switch to the running process
    jobs_before = n_jobs;
    do_switch(8'h14, 0, 1'b1);
    repeat (8) @(negedge clk);
    chk(n_jobs == jobs_before, "R5 no job", n_jobs, jobs_before);
    chk(active_bank == 2'd0 && active_valid, "R5 bank", int'(active_bank), 0);

    // R9: preload of a resident process
    jobs_before = n_jobs;
    @(negedge clk);
    pre_valid = 1'b1;
    pre_pid   = 8'h14;
    #1;
    chk(pre_ready, "R9 ready", int'(pre_ready), 1);
    @(negedge clk);
    pre_valid = 1'b0;
    repeat (8) @(negedge clk);
    chk(n_jobs == jobs_before, "R9 no job", n_jobs, jobs_before);

    chk(n_viol == 0, "R2 R10 R11 monitor", n_viol, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule